// File: doc/BRIEF.md
# Nine-Bit Asynchronous Receiver with Address Filtering

This block receives eleven-bit asynchronous serial frames: one start bit, nine data bits sent least significant bit first, and one stop bit. It is meant for a shared serial line that one master and several listeners use. On that line the ninth bit marks the frame type. A one means an address frame and a zero means a data frame. The baud rate is not generated here. The block runs from a one-cycle tick that occurs sixteen times per bit period. Each bit is decided by a vote of three samples taken around its middle.

Two modes set when a finished frame is reported. In filter mode the block reports a frame only if its ninth bit is one, so a listener that has not been addressed sees only address frames. In open mode every frame is reported. In open mode the ninth bit can also be used as an even-parity bit. The status output then carries a parity-error indication in place of the received ninth bit. A reported frame updates the byte output and the status bit, sets a sticky done flag and produces a one-cycle interrupt strobe. A software-side clear input resets the done flag.

Top module: `nine_bit_rx`

## Requirements
- R1: The nine data bits are taken least significant bit first. Bits 0 to 7 appear on `rx_byte_o`. When parity checking is inactive, the ninth bit appears on `bit9_o`.
- R2: With `addr_filter_i`=1, a frame is reported only when its ninth bit is 1. Reporting means updating the outputs, setting `done_o` and pulsing `irq_o`.
- R3: With `addr_filter_i`=0, every frame with a valid stop bit is reported, whatever its ninth bit.
- R4: With `addr_filter_i`=0 and `par_en_i`=1, `bit9_o` is 1 when the count of ones over the eight data bits plus the ninth bit is odd, and 0 when it is even. With `addr_filter_i`=1, `par_en_i` has no effect and `bit9_o` is the ninth bit.
- R5: `done_o` and `irq_o` rise just after the end of the stop bit, about 11 bit periods after the falling start edge. `irq_o` is high for exactly one clock cycle per reported frame.
- R6: A frame that filter mode rejects leaves `rx_byte_o`, `bit9_o` and `done_o` unchanged.
- R7: A low pulse on the line that is high again at the middle of the start bit is discarded. No frame is reported for it, and the next real frame is received correctly.
- R8: Each bit is decided by a majority of three samples at ticks 7, 8 and 9 of the bit. A disturbance that covers a single sample does not change the received value.
- R9: A frame whose stop bit is voted low is discarded without any output change.
- R10: `flag_clr_i` clears `done_o` on the next clock. When a clear and a frame report fall in the same cycle, `done_o` is left set.
- R11: After reset `rx_byte_o`, `bit9_o`, `done_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous to clk |
| os_tick_i | input | 1 | One-cycle pulse, sixteen per bit period |
| addr_filter_i | input | 1 | 1: report only frames with ninth bit 1; 0: report all frames |
| par_en_i | input | 1 | Enables even-parity checking on the ninth bit when not filtering |
| flag_clr_i | input | 1 | Clears the done flag |
| rx_byte_o | output | 8 | Last reported data byte |
| bit9_o | output | 1 | Ninth data bit, or the parity-error indication when parity is active |
| done_o | output | 1 | Sticky receive-done flag |
| irq_o | output | 1 | One-cycle strobe per reported frame |

## Verification
The clearing of the done flag and the report of a new frame can occur in the same clock cycle. The bench provokes this by holding `flag_clr_i` high for the whole of a frame and releasing it in the cycle after the interrupt strobe appears. It then requires `done_o` to still be 1, because the set must win. A separate clear pulse outside any frame must bring `done_o` back to 0 on the following cycle.

// File: rtl/nbr_pkg.sv
// Package: shared types and helpers for the nine-bit receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package nbr_pkg;

    // Frame reception phases
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three majority
    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/nbr_sync.sv
// Module: nbr_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops that reset to the idle (high) level.
// Assumes: STAGES >= 2.
module nbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nbr_vote.sv
// Module: nbr_vote
// Captures three line samples at the oversampling phases just before,
// at and just after the bit middle, and presents their majority.
// Assumes: OSR >= 8 so that the decision phase (MID+2) lies in the bit.
module nbr_vote #(
    parameter int OSR = 16,
    localparam int PW = $clog2(OSR),
    localparam int MID = OSR / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic          active_i,
    input  logic [PW-1:0] phase_i,
    output logic          vote_o
);

    logic [2:0] smp_q;

    for (genvar k = 0; k < 3; k++) begin : g_smp
        // Capture sample k at its own phase within the bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                smp_q[k] <= 1'b1;
            else if (tick_i && active_i && phase_i == PW'(MID - 1 + k))
                smp_q[k] <= line_i;
        end
    end

    assign vote_o = nbr_pkg::maj3(smp_q);

endmodule

// File: rtl/nbr_frame.sv
// Module: nbr_frame
// Frame sequencer: finds the start edge, confirms the start bit at
// mid-bit, shifts in nine data bits LSB first, checks the stop bit and
// pulses frame_done_o at the end of a stop bit that votes high.
// Assumes: tick_i is a one-cycle pulse, OSR per bit; line_i synchronized.
module nbr_frame
    import nbr_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8,
    localparam int PW = $clog2(OSR),
    localparam int IW = $clog2(DW + 1),
    localparam int MID = OSR / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic          vote_i,
    output logic [PW-1:0] phase_o,
    output logic          active_o,
    output logic          frame_done_o,
    output logic [DW-1:0] frame_data_o,
    output logic          frame_b9_o
);

    localparam logic [PW-1:0] DECIDE = PW'(MID + 2);
    localparam logic [PW-1:0] LAST   = PW'(OSR - 1);

    rx_state_t        state_q;
    logic [PW-1:0]    phase_q;
    logic [IW-1:0]    idx_q;
    logic [DW:0]      shreg_q;
    logic             prev_q;
    logic             stop_ok_q;
    logic             done_q;
    logic [PW-1:0]    phase_nx;

    // Phase counter advance with wrap at the end of a bit
    assign phase_nx = (phase_q == LAST) ? '0 : phase_q + 1'b1;

    // Sequence the frame on each oversampling tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            phase_q   <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            prev_q    <= 1'b1;
            stop_ok_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                prev_q <= line_i;
                case (state_q)
                    RX_IDLE: begin
                        if (prev_q && !line_i) begin
                            state_q <= RX_START;
                            phase_q <= PW'(1);
                        end
                    end
                    RX_START: begin
                        phase_q <= phase_nx;
                        if (phase_q == DECIDE && vote_i) begin
                            state_q <= RX_IDLE;
                            phase_q <= '0;
                        end else if (phase_q == LAST) begin
                            state_q <= RX_DATA;
                            idx_q   <= '0;
                        end
                    end
                    RX_DATA: begin
                        phase_q <= phase_nx;
                        if (phase_q == DECIDE)
                            shreg_q <= {vote_i, shreg_q[DW:1]};
                        if (phase_q == LAST) begin
                            if (idx_q == IW'(DW)) state_q <= RX_STOP;
                            else                  idx_q   <= idx_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        phase_q <= phase_nx;
                        if (phase_q == DECIDE)
                            stop_ok_q <= vote_i;
                        if (phase_q == LAST) begin
                            done_q  <= stop_ok_q;
                            state_q <= RX_IDLE;
                            phase_q <= '0;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign phase_o      = phase_q;
    assign active_o     = (state_q != RX_IDLE);
    assign frame_done_o = done_q;
    assign frame_data_o = shreg_q[DW-1:0];
    assign frame_b9_o   = shreg_q[DW];

    // R7: a start bit voted high at mid-bit returns the sequencer to idle
    p_glitch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q == RX_START && phase_q == DECIDE && vote_i)
        |=> (state_q == RX_IDLE))
        else $error("p_glitch_drop_r7");

    // R5: completion pulse lasts a single cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o)
        else $error("p_done_single_r5");

endmodule

// File: rtl/nbr_status.sv
// Module: nbr_status
// Applies the mode filter to a completed frame, holds the byte and the
// ninth-bit / parity-error status, the sticky done flag and the strobe.
// Assumes: frame_done_i is a single-cycle pulse with stable frame fields.
module nbr_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done_i,
    input  logic [DW-1:0] frame_data_i,
    input  logic          frame_b9_i,
    input  logic          addr_filter_i,
    input  logic          par_en_i,
    input  logic          flag_clr_i,
    output logic [DW-1:0] rx_byte_o,
    output logic          bit9_o,
    output logic          done_o,
    output logic          irq_o
);

    logic accept;
    logic par_active;
    logic par_err;

    // Filter mode passes only frames with the ninth bit set
    assign accept     = frame_done_i && (!addr_filter_i || frame_b9_i);
    assign par_active = !addr_filter_i && par_en_i;
    assign par_err    = ^{frame_b9_i, frame_data_i};

    // Update outputs on an accepted frame; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte_o <= '0;
            bit9_o    <= 1'b0;
            done_o    <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            irq_o <= accept;
            if (accept) begin
                rx_byte_o <= frame_data_i;
                bit9_o    <= par_active ? par_err : frame_b9_i;
                done_o    <= 1'b1;
            end else if (flag_clr_i) begin
                done_o <= 1'b0;
            end
        end
    end

    // R2: filter mode drops frames whose ninth bit is clear
    p_filter_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && addr_filter_i && !frame_b9_i) |=> !irq_o)
        else $error("p_filter_drop_r2");

    // R3 and R10: open mode reports every frame, done set even with a clear
    p_open_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !addr_filter_i) |=> (irq_o && done_o))
        else $error("p_open_report_r3");

    // R6: a rejected frame leaves the outputs untouched
    p_reject_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && addr_filter_i && !frame_b9_i)
        |=> ($stable(rx_byte_o) && $stable(bit9_o)))
        else $error("p_reject_keep_r6");

    // R10: a clear with no report empties the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !frame_done_i) |=> !done_o)
        else $error("p_clear_r10");

    // R5: the strobe is one cycle wide and implies the flag
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (done_o && !$past(irq_o)))
        else $error("p_irq_single_r5");

endmodule

// File: rtl/nine_bit_rx.sv
// Module: nine_bit_rx (top)
// Nine-bit asynchronous receiver with address filtering and optional
// even parity on the ninth bit. Composes synchronizer, voter, frame
// sequencer and status register.
// Assumes: os_tick_i pulses OSR times per bit period, one cycle each.
module nine_bit_rx #(
    parameter int OSR        = 16,
    parameter int DW         = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PW        = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_i,
    input  logic          os_tick_i,
    input  logic          addr_filter_i,
    input  logic          par_en_i,
    input  logic          flag_clr_i,
    output logic [DW-1:0] rx_byte_o,
    output logic          bit9_o,
    output logic          done_o,
    output logic          irq_o
);

    logic          line_s;
    logic          vote;
    logic [PW-1:0] phase;
    logic          active;
    logic          frame_done;
    logic [DW-1:0] frame_data;
    logic          frame_b9;

    nbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd_i),
        .sync_o  (line_s)
    );

    nbr_vote #(.OSR(OSR)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (os_tick_i),
        .line_i   (line_s),
        .active_i (active),
        .phase_i  (phase),
        .vote_o   (vote)
    );

    nbr_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (os_tick_i),
        .line_i       (line_s),
        .vote_i       (vote),
        .phase_o      (phase),
        .active_o     (active),
        .frame_done_o (frame_done),
        .frame_data_o (frame_data),
        .frame_b9_o   (frame_b9)
    );

    nbr_status #(.DW(DW)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_done_i  (frame_done),
        .frame_data_i  (frame_data),
        .frame_b9_i    (frame_b9),
        .addr_filter_i (addr_filter_i),
        .par_en_i      (par_en_i),
        .flag_clr_i    (flag_clr_i),
        .rx_byte_o     (rx_byte_o),
        .bit9_o        (bit9_o),
        .done_o        (done_o),
        .irq_o         (irq_o)
    );

endmodule

// File: tb/sim_nine_bit_rx.sv
// Directed bench for nine_bit_rx: one task per scenario.
module sim_nine_bit_rx;

    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick;
    logic       addr_filter = 1'b0;
    logic       par_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       bit9;
    logic       done;
    logic       irq;

    logic [1:0] tdiv = 2'd0;
    int         cyc = 0;
    int         irq_cnt = 0;
    int         irq_cyc = 0;
    int         start_cyc = 0;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Tick generator and cycle bookkeeping
    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        cyc  <= cyc + 1;
        if (irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_cyc <= cyc;
        end
    end
    assign tick = (tdiv == 2'd3);

    nine_bit_rx u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rxd_i         (rxd),
        .os_tick_i     (tick),
        .addr_filter_i (addr_filter),
        .par_en_i      (par_en),
        .flag_clr_i    (flag_clr),
        .rx_byte_o     (rx_byte),
        .bit9_o        (bit9),
        .done_o        (done),
        .irq_o         (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one bit period, optionally with a 4-clock inversion at mid-bit
    task automatic drive_bit(input logic v, input bit glitch);
        if (glitch) begin
            rxd = v;  repeat (30) @(negedge clk);
            rxd = ~v; repeat (4)  @(negedge clk);
            rxd = v;  repeat (30) @(negedge clk);
        end else begin
            rxd = v;  repeat (BITCLK) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9,
                              input logic stop_v, input int gbit);
        logic [8:0] bits;
        bits = {b9, d};
        @(negedge clk);
        start_cyc = cyc;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) drive_bit(bits[i], gbit == i);
        drive_bit(stop_v, 1'b0);
        rxd = 1'b1;
        repeat (48) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 byte", rx_byte, 0);
        chk("R11 bit9", bit9, 0);
        chk("R11 done", done, 0);
        chk("R11 irq", irq, 0);
    endtask

    task automatic t_open_mode();
        int n0;
        addr_filter = 1'b0; par_en = 1'b0;
        n0 = irq_cnt;
        send_frame(8'hA5, 1'b0, 1'b1, -1);
        chk("R1 byte", rx_byte, 8'hA5);
        chk("R1 bit9", bit9, 0);
        chk("R3 done data frame", done, 1);
        chk("R5 one strobe", irq_cnt - n0, 1);
        chk("R5 timing window", (irq_cyc - start_cyc >= 696 && irq_cyc - start_cyc <= 716) ? 1 : 0, 1);
        clear_flag();
        chk("R10 clear", done, 0);
        send_frame(8'h3C, 1'b1, 1'b1, -1);
        chk("R3 byte addr frame", rx_byte, 8'h3C);
        chk("R1 bit9 set", bit9, 1);
        chk("R3 count", irq_cnt - n0, 2);
    endtask

    task automatic t_filter_mode();
        int n0;
        addr_filter = 1'b1; par_en = 1'b1;
        clear_flag();
        n0 = irq_cnt;
        send_frame(8'h55, 1'b0, 1'b1, -1);
        chk("R2 no strobe", irq_cnt - n0, 0);
        chk("R6 done kept", done, 0);
        chk("R6 byte kept", rx_byte, 8'h3C);
        chk("R6 bit9 kept", bit9, 1);
        send_frame(8'h81, 1'b1, 1'b1, -1);
        chk("R2 addr strobe", irq_cnt - n0, 1);
        chk("R2 byte", rx_byte, 8'h81);
        chk("R4 parity ignored when filtering", bit9, 1);
    endtask

    task automatic t_parity();
        addr_filter = 1'b0; par_en = 1'b1;
        send_frame(8'h03, 1'b0, 1'b1, -1);
        chk("R4 even ok", bit9, 0);
        send_frame(8'h07, 1'b0, 1'b1, -1);
        chk("R4 odd error", bit9, 1);
        send_frame(8'h07, 1'b1, 1'b1, -1);
        chk("R4 even with ninth", bit9, 0);
        chk("R4 byte", rx_byte, 8'h07);
        par_en = 1'b0;
    endtask

    task automatic t_glitch();
        int n0;
        addr_filter = 1'b0;
        clear_flag();
        n0 = irq_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (800) @(negedge clk);
        chk("R7 no strobe", irq_cnt - n0, 0);
        chk("R7 done low", done, 0);
        send_frame(8'hC3, 1'b0, 1'b1, -1);
        chk("R7 next frame", rx_byte, 8'hC3);
    endtask

    task automatic t_majority();
        send_frame(8'h00, 1'b0, 1'b1, 2);
        chk("R8 low bit kept", rx_byte, 8'h00);
        send_frame(8'hFF, 1'b1, 1'b1, 5);
        chk("R8 high bit kept", rx_byte, 8'hFF);
        chk("R8 ninth", bit9, 1);
    endtask

    task automatic t_bad_stop();
        int n0;
        clear_flag();
        n0 = irq_cnt;
        send_frame(8'h12, 1'b0, 1'b0, -1);
        repeat (200) @(negedge clk);
        chk("R9 no strobe", irq_cnt - n0, 0);
        chk("R9 byte kept", rx_byte, 8'hFF);
        chk("R9 done low", done, 0);
        send_frame(8'h34, 1'b0, 1'b1, -1);
        chk("R9 recovers", rx_byte, 8'h34);
    endtask

    task automatic t_collision();
        @(negedge clk); flag_clr = 1'b1;
        fork
            send_frame(8'h5A, 1'b0, 1'b1, -1);
            begin
                while (!irq) @(negedge clk);
                flag_clr = 1'b0;
                chk("R10 set wins", done, 1);
            end
        join
        chk("R10 byte", rx_byte, 8'h5A);
        clear_flag();
        chk("R10 cleared after", done, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_open_mode();
        t_filter_mode();
        t_parity();
        t_glitch();
        t_majority();
        t_bad_stop();
        t_collision();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule